// File: doc/BRIEF.md
# Vertical Capture Window Line Gate

This block sits in a video capture path and decides, one line at a time, whether the current video line is passed on for capture. It counts line-start strobes from the most recent field-start strobe and compares that line number with a programmed first line and last line. When windowing is off, every line is captured. When windowing is on in progressive mode, the window applies to the whole frame. When windowing is on in interlaced mode, the window applies only to the odd field, and lines of the even field pass freely.

Both line limits are inclusive. A window whose last line is below its first line captures nothing. A one-cycle completion pulse marks the line start that follows the last windowed line. Downstream logic uses it to close the frame or the odd field. The limits, the mode bit and the enable are plain input ports that the surrounding register block holds steady.

Top module: `vcap_line_gate`

## Requirements
- R1: A field-start strobe sets the line number to 0. Each later line-start strobe adds one to it, so after k strobes the line number is k. The value shows on `captureEn` when the window is set to a single line.
- R2: With `winEnable`=1 and `interlaced`=0, `captureEn` is 1 exactly when startLine <= line number <= endLine. Both limits are inclusive.
- R3: With `winEnable`=0, `captureEn` is 1 for every line, whatever the values of startLine and endLine.
- R4: With `interlaced`=1, the window gates only lines where `oddField`=1. Lines with `oddField`=0 have `captureEn`=1. With `interlaced`=0, `oddField` has no effect.
- R5: When the window is gated and valid, a line-start strobe that arrives while the line number equals endLine makes `captureDone` high for exactly one cycle, starting on the next clock. This happens at most once per field.
- R6: When `winEnable`=1 and endLine < startLine, gated lines have `captureEn`=0 and `captureDone` never pulses.
- R7: If a field-start and a line-start come in the same cycle, the field-start wins. The line number becomes 0 and no completion pulse is produced. The once-per-field limit is re-armed.
- R8: The line number saturates at 4095 (all ones at the default 12-bit width). Further strobes leave it at 4095.
- R9: After reset, the line number is 0 and `captureDone` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe at the start of each line |
| fieldStart | input | 1 | One-cycle strobe at the start of each field or frame |
| oddField | input | 1 | 1 while the current field is odd |
| interlaced | input | 1 | 1 = interlaced, 0 = progressive |
| winEnable | input | 1 | 1 = apply the vertical window |
| startLine | input | 12 | First captured line, inclusive |
| endLine | input | 12 | Last captured line, inclusive |
| captureEn | output | 1 | Current line is to be captured |
| captureDone | output | 1 | One-cycle pulse after the last windowed line |

## Verification
Two functions can fall in the same clock edge: clearing the count at a field start, and stepping past the end line, which would raise the completion pulse. The bench provokes this by asserting field-start and line-start together while the count sits on endLine. It then judges the outcome from the ports. `captureDone` must stay low, and a single-line window at line 0 must report capture, which shows the count was cleared. After that, a fresh pass through the window must pulse again, which shows the once-per-field limit was re-armed.

// File: rtl/vgate_pkg.sv
package vgate_pkg;
  // Commands from control to the line counter datapath
  typedef struct packed {
    logic clear;
    logic step;
  } cntCmd_t;
endpackage

// File: rtl/vgate_datapath.sv
module vgate_datapath
  import vgate_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  cntCmd_t           cmd,
  input  logic [LINE_W-1:0] startLine,
  input  logic [LINE_W-1:0] endLine,
  output logic [LINE_W-1:0] lineCount,
  output logic              inWin,
  output logic              atEnd,
  output logic              winValid
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCount <= '0;
    end else if (cmd.clear) begin
      lineCount <= '0;
    end else if (cmd.step && (lineCount != LINE_MAX)) begin
      lineCount <= lineCount + 1'b1;
    end
  end

  always_comb begin
    winValid = (startLine <= endLine);
    inWin    = (lineCount >= startLine) && (lineCount <= endLine);
    atEnd    = (lineCount == endLine);
  end
endmodule

// File: rtl/vgate_ctrl.sv
module vgate_ctrl
  import vgate_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineStart,
  input  logic    fieldStart,
  input  logic    oddField,
  input  logic    interlaced,
  input  logic    winEnable,
  input  logic    inWin,
  input  logic    atEnd,
  input  logic    winValid,
  output cntCmd_t cmd,
  output logic    captureEn,
  output logic    captureDone
);
  logic gated;
  logic finishHit;
  logic doneQ;
  logic doneSeen;

  always_comb begin
    cmd.clear = fieldStart;
    cmd.step  = lineStart && !fieldStart;
    gated     = winEnable && (!interlaced || oddField);
    captureEn = gated ? (winValid && inWin) : 1'b1;
    finishHit = cmd.step && gated && winValid && atEnd && !doneSeen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneQ    <= 1'b0;
      doneSeen <= 1'b0;
    end else begin
      doneQ    <= finishHit;
      doneSeen <= fieldStart ? 1'b0 : (doneSeen || finishHit);
    end
  end

  assign captureDone = doneQ;
endmodule

// File: rtl/vcap_line_gate.sv
module vcap_line_gate
  import vgate_pkg::*;
#(
  parameter int LINE_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineStart,
  input  logic              fieldStart,
  input  logic              oddField,
  input  logic              interlaced,
  input  logic              winEnable,
  input  logic [LINE_W-1:0] startLine,
  input  logic [LINE_W-1:0] endLine,
  output logic              captureEn,
  output logic              captureDone
);
  cntCmd_t           cmd;
  logic [LINE_W-1:0] lineCount;
  logic              inWin;
  logic              atEnd;
  logic              winValid;

  vgate_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldStart(fieldStart),
    .oddField(oddField), .interlaced(interlaced), .winEnable(winEnable),
    .inWin(inWin), .atEnd(atEnd), .winValid(winValid), .cmd(cmd),
    .captureEn(captureEn), .captureDone(captureDone)
  );

  vgate_datapath #(.LINE_W(LINE_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startLine(startLine), .endLine(endLine),
    .lineCount(lineCount), .inWin(inWin), .atEnd(atEnd), .winValid(winValid)
  );
endmodule

// File: rtl/vgate_checker.sv
module vgate_checker #(
  parameter int LINE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineStart,
  input logic              fieldStart,
  input logic              oddField,
  input logic              interlaced,
  input logic              winEnable,
  input logic [LINE_W-1:0] startLine,
  input logic [LINE_W-1:0] endLine,
  input logic [LINE_W-1:0] lineCount,
  input logic              captureEn,
  input logic              captureDone
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  assert_field_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |=> (lineCount == '0));

  assert_line_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !fieldStart && lineCount != LINE_MAX) |=> (lineCount == $past(lineCount) + 1'b1));

  assert_saturate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lineCount == LINE_MAX && !fieldStart) |=> (lineCount == LINE_MAX));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rstN)
    captureDone |=> !captureDone);

  assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    captureDone |-> ($past(lineStart) && !$past(fieldStart)));

  assert_done_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    captureDone |-> ($past(winEnable) && $past(startLine <= endLine)));

  assert_open_R3: assert property (@(posedge clk) disable iff (!rstN)
    !winEnable |-> captureEn);

  assert_even_pass_R4: assert property (@(posedge clk) disable iff (!rstN)
    (interlaced && !oddField) |-> captureEn);

  assert_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (winEnable && !interlaced && startLine > endLine) |-> !captureEn);
endmodule

bind vcap_line_gate vgate_checker #(.LINE_W(LINE_W)) u_chk (
  .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldStart(fieldStart),
  .oddField(oddField), .interlaced(interlaced), .winEnable(winEnable),
  .startLine(startLine), .endLine(endLine), .lineCount(lineCount),
  .captureEn(captureEn), .captureDone(captureDone)
);

// File: tb/vcap_line_gate_tb.sv
module vcap_line_gate_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0, fieldStart = 1'b0, oddField = 1'b0;
  logic interlaced = 1'b0, winEnable = 1'b0;
  logic [11:0] startLine = '0, endLine = '0;
  logic captureEn, captureDone;
  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  vcap_line_gate u_dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .fieldStart(fieldStart),
    .oddField(oddField), .interlaced(interlaced), .winEnable(winEnable),
    .startLine(startLine), .endLine(endLine), .captureEn(captureEn),
    .captureDone(captureDone)
  );

  // {interlaced, odd, enable, start[12], end[12], line[12], expectedEn}
  localparam int NV = 14;
  localparam logic [39:0] VECS [0:NV-1] = '{
    {1'b0,1'b0,1'b1,12'd5, 12'd10,12'd4, 1'b0},  // R2 below window
    {1'b0,1'b0,1'b1,12'd5, 12'd10,12'd5, 1'b1},  // R2 first line
    {1'b0,1'b0,1'b1,12'd5, 12'd10,12'd10,1'b1},  // R2 last line
    {1'b0,1'b0,1'b1,12'd5, 12'd10,12'd11,1'b0},  // R2 above window
    {1'b0,1'b0,1'b0,12'd5, 12'd10,12'd2, 1'b1},  // R3
    {1'b0,1'b0,1'b0,12'd10,12'd5, 12'd7, 1'b1},  // R3 inverted limits ignored
    {1'b0,1'b0,1'b1,12'd10,12'd5, 12'd7, 1'b0},  // R6
    {1'b0,1'b0,1'b1,12'd10,12'd5, 12'd10,1'b0},  // R6
    {1'b1,1'b1,1'b1,12'd3, 12'd6, 12'd2, 1'b0},  // R4 odd gated
    {1'b1,1'b1,1'b1,12'd3, 12'd6, 12'd4, 1'b1},  // R4 odd inside
    {1'b1,1'b0,1'b1,12'd3, 12'd6, 12'd2, 1'b1},  // R4 even passes
    {1'b1,1'b0,1'b1,12'd3, 12'd6, 12'd9, 1'b1},  // R4 even passes
    {1'b0,1'b0,1'b1,12'd3, 12'd6, 12'd8, 1'b0},  // R4 odd flag ignored
    {1'b0,1'b0,1'b1,12'd0, 12'd0, 12'd0, 1'b1}   // R1 line 0 after field start
  };

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic pulseField();
    @(negedge clk) fieldStart = 1'b1;
    @(negedge clk) fieldStart = 1'b0;
  endtask

  task automatic pulseLine();
    @(negedge clk) lineStart = 1'b1;
    @(negedge clk) lineStart = 1'b0;
  endtask

  task automatic setWin(input logic il, input logic od, input logic en,
                        input logic [11:0] s, input logic [11:0] e);
    interlaced = il; oddField = od; winEnable = en; startLine = s; endLine = e;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    setWin(1'b0, 1'b0, 1'b1, 12'd0, 12'd0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 done low", captureDone, 1'b0);
    check("R9 count zero", captureEn, 1'b1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      setWin(VECS[i][39], VECS[i][38], VECS[i][37], VECS[i][36:25], VECS[i][24:13]);
      pulseField();
      for (int k = 0; k < int'(VECS[i][12:1]); k++) pulseLine();
      check($sformatf("R2/R3/R4/R6 vector %0d", i), captureEn, VECS[i][0]);
    end

    // R5: completion pulse, progressive window 2..4
    setWin(1'b0, 1'b0, 1'b1, 12'd2, 12'd4);
    pulseField();
    for (int k = 0; k < 4; k++) begin
      pulseLine();
      check("R5 no early pulse", captureDone, 1'b0);
    end
    pulseLine();
    check("R5 pulse", captureDone, 1'b1);
    @(negedge clk);
    check("R5 one cycle", captureDone, 1'b0);
    check("R2 past end", captureEn, 1'b0);
    pulseLine();
    check("R5 no repeat", captureDone, 1'b0);

    // R4/R5: even field in interlaced mode never completes
    setWin(1'b1, 1'b0, 1'b1, 12'd2, 12'd4);
    pulseField();
    for (int k = 0; k < 6; k++) begin
      pulseLine();
      check("R4 even no pulse", captureDone, 1'b0);
    end

    // R4/R5: odd field completes
    setWin(1'b1, 1'b1, 1'b1, 12'd2, 12'd4);
    pulseField();
    for (int k = 0; k < 4; k++) pulseLine();
    pulseLine();
    check("R5 odd field pulse", captureDone, 1'b1);

    // R6: inverted limits never complete
    setWin(1'b0, 1'b0, 1'b1, 12'd6, 12'd3);
    pulseField();
    for (int k = 0; k < 10; k++) begin
      pulseLine();
      check("R6 no pulse", captureDone, 1'b0);
    end

    // R7: field start collides with the finishing line start
    setWin(1'b0, 1'b0, 1'b1, 12'd2, 12'd3);
    pulseField();
    for (int k = 0; k < 3; k++) pulseLine();
    @(negedge clk) begin lineStart = 1'b1; fieldStart = 1'b1; end
    @(negedge clk) begin lineStart = 1'b0; fieldStart = 1'b0; end
    check("R7 no pulse on clash", captureDone, 1'b0);
    setWin(1'b0, 1'b0, 1'b1, 12'd0, 12'd0);
    #1;
    check("R7 count cleared", captureEn, 1'b1);
    setWin(1'b0, 1'b0, 1'b1, 12'd2, 12'd3);
    for (int k = 0; k < 3; k++) pulseLine();
    pulseLine();
    check("R7 re-armed pulse", captureDone, 1'b1);

    // R8: saturation at 4095 with window 4095..4095
    setWin(1'b0, 1'b0, 1'b1, 12'd4095, 12'd4095);
    pulseField();
    for (int k = 0; k < 4095; k++) pulseLine();
    check("R8 reached top", captureEn, 1'b1);
    check("R5 no pulse at top", captureDone, 1'b0);
    pulseLine();
    check("R8 held at top", captureEn, 1'b1);
    check("R5 pulse at top", captureDone, 1'b1);
    pulseLine();
    check("R8 still top", captureEn, 1'b1);
    check("R5 single at top", captureDone, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule